// File: doc/BRIEF.md
# Floating-Point Control and Status Register with Trap Gating

This block is the control and status register of a floating-point unit. It holds the rounding-mode field, a set of sticky exception flags and a trap enable for each of the five IEEE exceptions. It also holds cause bits that describe the most recent completed operation.

The arithmetic datapath reports raw exception indications when an operation completes. The register evaluates them against the current enables and does three things in the same cycle. It raises a trap request with cause bits, it either allows or blocks the write of the destination result register, and it updates the flags for exceptions that did not trap.

Software reads the whole register as one word and replaces it with one word. There are no partial writes.

Top module: `fp_csr`

## Requirements
- R1: After reset every register field is zero, so the rounding mode is nearest-even and all flags, enables and cause bits are clear.
- R2: A software write loads the register layout used throughout: rounding mode in bits 1..0, flags in bits 6..2, enables in bits 11..7 and cause in bits 17..12. The new value is visible on `rd_data_o` in the next cycle. All bits above 17 always read as zero.
- R3: `rnd_mode_o` equals bits 1..0 of the register. The encodings are 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity.
- R4: Within the flag, enable and cause fields, and on `exc_i`, the bit positions are: bit 0 inexact, bit 1 underflow (tininess on `exc_i`), bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. Cause bit 5 is the unimplemented-operation bit.
- R5: In the cycle where `op_done_i` is high, `trap_o` is high when any evaluated exception has its enable set or the operation is unimplemented. In that same cycle, `wb_en_o` is high exactly when `trap_o` is low. Both outputs are low when no operation completes.
- R6: An unimplemented operation traps whatever the enables are. It has no flag and no enable bit.
- R7: Underflow is evaluated from tininess alone when the underflow enable is set. When the enable is clear, it requires both tininess and inexact.
- R8: An overflow whose enable is clear also raises the inexact exception.
- R9: Flags are sticky. A completed operation that does not trap ORs its evaluated exceptions into the flags. A trapping operation leaves the flags unchanged. Only a software write clears flags.
- R10: Every completed operation overwrites the cause field with its evaluated exceptions and the unimplemented bit. This happens whether or not the operation traps. `trap_cause_o` shows the same value during the completing cycle, and the cause field holds its value when no operation completes.
- R11: When a software write and an operation completion fall in the same cycle, the register takes the written value. The trap and writeback outputs for that operation are still decided from the enables held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | XLEN | Software write value |
| rd_data_o | output | XLEN | Current register value |
| op_done_i | input | 1 | Datapath operation completes this cycle |
| exc_i | input | 5 | Raw exception indications of the completing operation |
| unimpl_i | input | 1 | Completing operation is unimplemented or reserved |
| rnd_mode_o | output | 2 | Current rounding mode |
| trap_o | output | 1 | Trap request for the completing operation |
| trap_cause_o | output | 6 | Cause bits of the completing operation |
| wb_en_o | output | 1 | Result register write permitted |

## Verification
The bench builds the block with the default XLEN of 32. This leaves fourteen bits above the architected field, so writing all ones exposes any bit that should read as zero. A behavioural model predicts the trap, writeback and cause outputs in the completing cycle and the register contents one cycle later. It is compared every clock across directed cases and a long stretch of mixed writes and operations. The directed cases cover trapped against untrapped underflow, overflow that feeds inexact, unimplemented operations with no enables set, and a write that coincides with an operation completion.

// File: rtl/fp_csr_pkg.sv
`timescale 1ns/1ps
package fp_csr_pkg;
  localparam int N_EXC     = 5;
  localparam int CAUSE_W   = N_EXC + 1;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = RM_W;
  localparam int EN_LSB    = FLAG_LSB + N_EXC;
  localparam int CAUSE_LSB = EN_LSB + N_EXC;
  localparam int CSR_W     = CAUSE_LSB + CAUSE_W;

  localparam int EX_INX   = 0;
  localparam int EX_UNF   = 1;
  localparam int EX_OVF   = 2;
  localparam int EX_DZ    = 3;
  localparam int EX_INV   = 4;
  localparam int CA_UNIMP = 5;

  typedef enum logic [RM_W-1:0] {
    RM_RNE = 2'd0,
    RM_RTZ = 2'd1,
    RM_RUP = 2'd2,
    RM_RDN = 2'd3
  } rmode_e;
endpackage

// File: rtl/fp_csr_eval.sv
`timescale 1ns/1ps
module fp_csr_eval
  import fp_csr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_done_i,
  input  logic [N_EXC-1:0]   exc_i,
  input  logic               unimpl_i,
  input  logic [N_EXC-1:0]   en_i,
  output logic [N_EXC-1:0]   evt_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               trap_o,
  output logic               wb_en_o
);
  logic trap_hit;

  always_comb begin
    evt_o = exc_i;
    // untrapped underflow needs loss of accuracy as well as tininess
    evt_o[EX_UNF] = exc_i[EX_UNF] & (en_i[EX_UNF] | exc_i[EX_INX]);
    // untrapped overflow delivers an inexact result
    evt_o[EX_INX] = exc_i[EX_INX] | (exc_i[EX_OVF] & ~en_i[EX_OVF]);
    trap_hit = (|(evt_o & en_i)) | unimpl_i;
    trap_o   = op_done_i & trap_hit;
    wb_en_o  = op_done_i & ~trap_hit;
    cause_o  = op_done_i ? {unimpl_i, evt_o} : '0;
  end

  AST_UNIMP_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i && unimpl_i |-> trap_o && !wb_en_o); // R6
  AST_WB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i |-> (trap_o != wb_en_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_done_i |-> !trap_o && !wb_en_o); // R5
  AST_UNF_UNTRAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i && !en_i[EX_UNF] && !exc_i[EX_INX] && !exc_i[EX_OVF] |-> !trap_cause_unf()); // R7

  function automatic logic trap_cause_unf();
    return cause_o[EX_UNF];
  endfunction
endmodule

// File: rtl/fp_csr_regs.sv
`timescale 1ns/1ps
module fp_csr_regs
  import fp_csr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CSR_W-1:0]   wr_csr_i,
  input  logic               op_done_i,
  input  logic               trap_i,
  input  logic [N_EXC-1:0]   evt_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [RM_W-1:0]    rm_o,
  output logic [N_EXC-1:0]   flags_o,
  output logic [N_EXC-1:0]   en_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic flag_set;
  assign flag_set = op_done_i & ~trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rm_o    <= RM_RNE;
      en_o    <= '0;
      cause_o <= '0;
    end else if (wr_en_i) begin
      rm_o    <= wr_csr_i[RM_W-1:0];
      en_o    <= wr_csr_i[EN_LSB +: N_EXC];
      cause_o <= wr_csr_i[CAUSE_LSB +: CAUSE_W];
    end else if (op_done_i) begin
      cause_o <= cause_i;
    end
  end

  for (genvar g = 0; g < N_EXC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   flags_o[g] <= 1'b0;
      else if (wr_en_i)              flags_o[g] <= wr_csr_i[FLAG_LSB+g];
      else if (flag_set && evt_i[g]) flags_o[g] <= 1'b1;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R9
  AST_TRAP_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && !wr_en_i |=> $stable(flags_o)); // R9
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ({cause_o, en_o, flags_o, rm_o} == $past(wr_csr_i))); // R11
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !op_done_i |=> $stable(cause_o)); // R10
  AST_CAUSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && op_done_i |=> cause_o == $past(cause_i)); // R10
endmodule

// File: rtl/fp_csr.sv
`timescale 1ns/1ps
module fp_csr
  import fp_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [XLEN-1:0]    wr_data_i,
  output logic [XLEN-1:0]    rd_data_o,
  input  logic               op_done_i,
  input  logic [N_EXC-1:0]   exc_i,
  input  logic               unimpl_i,
  output logic [RM_W-1:0]    rnd_mode_o,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] trap_cause_o,
  output logic               wb_en_o
);
  localparam int PAD_W = XLEN - CSR_W;

  logic [N_EXC-1:0]   evt;
  logic [N_EXC-1:0]   flags_q;
  logic [N_EXC-1:0]   en_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [RM_W-1:0]    rm_q;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[XLEN-1:CSR_W];

  fp_csr_eval u_eval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_done_i (op_done_i),
    .exc_i     (exc_i),
    .unimpl_i  (unimpl_i),
    .en_i      (en_q),
    .evt_o     (evt),
    .cause_o   (trap_cause_o),
    .trap_o    (trap_o),
    .wb_en_o   (wb_en_o)
  );

  fp_csr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_csr_i  (wr_data_i[CSR_W-1:0]),
    .op_done_i (op_done_i),
    .trap_i    (trap_o),
    .evt_i     (evt),
    .cause_i   (trap_cause_o),
    .rm_o      (rm_q),
    .flags_o   (flags_q),
    .en_o      (en_q),
    .cause_o   (cause_q)
  );

  assign rnd_mode_o = rm_q;
  assign rd_data_o  = {{PAD_W{1'b0}}, cause_q, en_q, flags_q, rm_q};

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[XLEN-1:CSR_W] == '0); // R2
  AST_RM_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rnd_mode_o == $past(wr_data_i[RM_W-1:0])); // R3
endmodule

// File: tb/tb_fp_csr.sv
`timescale 1ns/1ps
module tb_fp_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        op_done_i = 1'b0;
  logic [4:0]  exc_i = '0;
  logic        unimpl_i = 1'b0;
  logic [1:0]  rnd_mode_o;
  logic        trap_o;
  logic [5:0]  trap_cause_o;
  logic        wb_en_o;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_rm = '0;
  logic [4:0] m_fl = '0;
  logic [4:0] m_en = '0;
  logic [5:0] m_ca = '0;

  always #2.5 clk_i = ~clk_i;

  fp_csr #(.XLEN(32)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .op_done_i(op_done_i), .exc_i(exc_i),
    .unimpl_i(unimpl_i), .rnd_mode_o(rnd_mode_o), .trap_o(trap_o),
    .trap_cause_o(trap_cause_o), .wb_en_o(wb_en_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic step(input logic wr, input logic [31:0] wd, input logic op,
                      input logic [4:0] ex, input logic un, input string req);
    logic [4:0] ev;
    logic th;
    chk(req, "rd_data", rd_data_o, {14'd0, m_ca, m_en, m_fl, m_rm});
    chk(req, "rnd_mode", {30'd0, rnd_mode_o}, {30'd0, m_rm});
    wr_en_i = wr; wr_data_i = wd; op_done_i = op; exc_i = ex; unimpl_i = un;
    #1;
    ev = ex;
    if (ex[1] && !m_en[1] && !ex[0]) ev[1] = 1'b0;
    if (ex[2] && !m_en[2]) ev[0] = 1'b1;
    th = ((ev & m_en) != 5'd0) || un;
    chk(req, "trap", {31'd0, trap_o}, {31'd0, op && th});
    chk(req, "wb_en", {31'd0, wb_en_o}, {31'd0, op && !th});
    chk(req, "cause_out", {26'd0, trap_cause_o}, op ? {26'd0, un, ev} : 32'd0);
    @(posedge clk_i);
    if (wr) begin
      m_rm = wd[1:0]; m_fl = wd[6:2]; m_en = wd[11:7]; m_ca = wd[17:12];
    end else if (op) begin
      m_ca = {un, ev};
      if (!th) m_fl = m_fl | ev;
    end
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] csr(input logic [5:0] ca, input logic [4:0] en,
                                      input logic [4:0] fl, input logic [1:0] rm);
    return {14'd0, ca, en, fl, rm};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "reset", rd_data_o, 32'd0);
    // R3: each rounding mode code
    for (int k = 0; k < 4; k++) step(1'b1, csr(0, 0, 0, 2'(k)), 1'b0, 5'd0, 1'b0, "R3");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R3");
    // R2: all ones write, upper bits read zero
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, "R2");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R2");
    chk("R2", "upper", rd_data_o, 32'h0003_FFFF);
    step(1'b1, 32'd0, 1'b0, 5'd0, 1'b0, "R9");
    // R4/R9: each exception untrapped sets its own flag
    for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b1, 5'b1 << k, 1'b0, "R4");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R9");
    step(1'b1, 32'd0, 1'b0, 5'd0, 1'b0, "R9");
    // R8: untrapped overflow raises inexact
    step(1'b0, 0, 1'b1, 5'b00100, 1'b0, "R8");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R8");
    chk("R8", "flags", rd_data_o, csr(6'b000101, 0, 5'b00101, 0));
    // R7: underflow untrapped, tininess only vs tininess plus inexact
    step(1'b1, 32'd0, 1'b0, 5'd0, 1'b0, "R7");
    step(1'b0, 0, 1'b1, 5'b00010, 1'b0, "R7");
    step(1'b0, 0, 1'b1, 5'b00011, 1'b0, "R7");
    // R7: underflow trapped on tininess alone
    step(1'b1, csr(0, 5'b00010, 0, 0), 1'b0, 5'd0, 1'b0, "R7");
    step(1'b0, 0, 1'b1, 5'b00010, 1'b0, "R7");
    // R5/R9/R10: trapped overflow, flags kept, cause set
    step(1'b1, csr(0, 5'b00100, 5'b10000, 1), 1'b0, 5'd0, 1'b0, "R5");
    step(1'b0, 0, 1'b1, 5'b00100, 1'b0, "R5");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R10");
    chk("R10", "cause_hold", rd_data_o, csr(6'b000100, 5'b00100, 5'b10000, 1));
    // R6: unimplemented with no enables
    step(1'b1, 32'd0, 1'b0, 5'd0, 1'b0, "R6");
    step(1'b0, 0, 1'b1, 5'd0, 1'b1, "R6");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R6");
    chk("R6", "no_flag", rd_data_o, csr(6'b100000, 0, 0, 0));
    // R11: write and trapping op in the same cycle
    step(1'b1, csr(0, 5'b11111, 0, 0), 1'b0, 5'd0, 1'b0, "R11");
    step(1'b1, csr(0, 0, 5'b01000, 2), 1'b1, 5'b10000, 1'b0, "R11");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R11");
    chk("R11", "wr_wins", rd_data_o, csr(0, 0, 5'b01000, 2));
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 7) == 0, $urandom, 1'($urandom_range(0, 1)),
           5'($urandom), $urandom_range(0, 7) == 0, "R5");
    step(1'b0, 0, 1'b0, 5'd0, 1'b0, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule